// File: doc/BRIEF.md
# Zero-Skipping Sparse Dot-Product Engine

This block computes the dot product of a sparse 16-element activation vector with a dense 16-entry weight vector. It performs arithmetic only for the lanes that a 16-bit occupancy mask marks as non-zero. The non-zero activations are stored packed in a 1024-entry activation store, so the k-th set lane of a mask reads the activation at `offset + k`. The weight for lane `i` is read from weight entry `i`.

A job begins with a one-cycle `start_i` pulse that carries the mask and the activation base offset. An index walker emits one set lane per cycle, lowest lane first. Both stores are synchronous and have one cycle of read latency. The read data passes through an operand register stage and then a signed multiply-accumulate stage. `done_o` rises once the final product has reached the accumulator.

Longer vectors are processed as a sequence of jobs, one per mask word, each with its own absolute offset. The control pins are plain level and pulse signals, with no valid/ready stream. The caller preloads both stores through the write ports while the engine is idle.

Top module: `sparse_mac`

## Requirements
- R1: After reset, `result_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse accepted while idle clears the accumulator. When the job ends, `result_o` equals the sum over the set mask bits, in ascending bit order, of weight[i] times activation[(offset + k) mod 1024], where k is the rank of bit i among the set bits (0 for the lowest).
- R3: Weights and activations are signed 16-bit two's-complement values. Each product is sign-extended to 32 bits, and the sum wraps modulo 2^32.
- R4: An all-zero mask completes with `result_o` = 0, and `done_o` reads high one clock edge after the edge that samples `start_i`.
- R5: `done_o` rises only after the last product has been accumulated. It then stays high, with `result_o` unchanged, until the next accepted start.
- R6: A `start_i` pulse that arrives while a job is running is ignored, and the running job completes with its own result.
- R7: Writes on the weight or activation preload ports while a job is running are ignored, so the stored contents stay unchanged.
- R8: The activation address increments by one per set bit and wraps from 1023 to 0.
- R9: A mask with all 16 bits set yields the full dense dot product.
- R10: For a mask with n ≥ 1 set bits, `done_o` first reads high n + 3 clock edges after the edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a job (accepted only while idle) |
| bitmap_i | input | 16 | Non-zero lane mask, bit i = lane i |
| offset_i | input | 10 | Absolute activation address of the first packed non-zero |
| wt_we_i | input | 1 | Weight store write enable |
| wt_addr_i | input | 4 | Weight store write address |
| wt_data_i | input | 16 | Weight store write data |
| act_we_i | input | 1 | Activation store write enable |
| act_addr_i | input | 10 | Activation store write address |
| act_data_i | input | 16 | Activation store write data |
| result_o | output | 32 | Accumulated dot product |
| done_o | output | 1 | Job complete, held until next start |

## Verification
The bench covers the corner cases where the pipeline bookkeeping is most likely to slip.

- **Empty mask.** A design that waits for a non-existent product would hang, and one that accumulates a stray stage would return a non-zero result.
- **Single-bit mask at the top lane with offset 1023, and a mask whose packed run crosses address 1023.** These catch an address that is lost or saturated instead of wrapped. Such a design fetches the wrong activation or the zero at address 0.
- **Done timing.** The exact latency is measured. A done that fires one stage early returns a sum missing its final product.
- **Start and preload writes during a running job.** A restart or a corrupted store shows up as a changed result.
- **Saturating and negative operands.** These expose unsigned multiplication or missing sign extension.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int unsigned LANES     = 16;
  localparam int unsigned ACT_DEPTH = 1024;
  localparam int unsigned OPND_W    = 16;
  localparam int unsigned ACC_W     = 32;
endpackage

// File: rtl/smac_mem.sv
// Synchronous single-port store: one address shared by write and read,
// read data registered (one cycle latency).
module smac_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/smac_index_dec.sv
// Walks the occupancy mask lowest set bit first, one lane per cycle,
// and advances the packed activation pointer alongside.
module smac_index_dec #(
  parameter int unsigned LANES = 16,
  parameter int unsigned AW    = 10,
  localparam int unsigned IW   = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] mask,
  input  logic [AW-1:0]    base,
  output logic             valid,
  output logic [IW-1:0]    lane,
  output logic [AW-1:0]    fetch
);
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] lowest;
  logic [AW-1:0]    ptr_q;

  assign valid  = |pend_q;
  assign lowest = pend_q & (~pend_q + 1'b1);
  assign fetch  = ptr_q;

  always_comb begin
    lane = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lowest[i]) lane = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      pend_q <= mask;
      ptr_q  <= base;
    end else if (valid) begin
      pend_q <= pend_q & (pend_q - 1'b1);
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  AST_ONE_LANE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !load |=> $countones(pend_q) == $countones($past(pend_q)) - 1); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !load |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R8
endmodule

// File: rtl/smac_mac.sv
// Valid alignment with the store latency, operand register stage,
// and signed multiply-accumulate stage.
module smac_mac #(
  parameter int unsigned OPND_W = 16,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned PW    = 2 * OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              issue,
  input  logic [OPND_W-1:0] w_rd,
  input  logic [OPND_W-1:0] a_rd,
  output logic [ACC_W-1:0]  acc,
  output logic              busy
);
  logic                     rd_v_q;
  logic                     op_v_q;
  logic [OPND_W-1:0]        w_q, a_q;
  logic signed [PW-1:0]     prod;
  logic [ACC_W-1:0]         prod_ext;
  logic [ACC_W-1:0]         acc_q;

  assign prod = $signed(w_q) * $signed(a_q);

  generate
    if (ACC_W > PW) begin : g_sext
      assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v_q <= 1'b0;
      op_v_q <= 1'b0;
      w_q    <= '0;
      a_q    <= '0;
      acc_q  <= '0;
    end else begin
      rd_v_q <= issue;
      op_v_q <= rd_v_q;
      if (rd_v_q) begin
        w_q <= w_rd;
        a_q <= a_rd;
      end
      if (clr)         acc_q <= '0;
      else if (op_v_q) acc_q <= acc_q + prod_ext;
    end
  end

  assign acc  = acc_q;
  assign busy = rd_v_q | op_v_q;

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0); // R2
endmodule

// File: rtl/sparse_mac.sv
module sparse_mac
  import smac_pkg::*;
#(
  parameter int unsigned LN   = LANES,
  parameter int unsigned ADEP = ACT_DEPTH,
  parameter int unsigned OW   = OPND_W,
  parameter int unsigned AW_R = ACC_W,
  localparam int unsigned IW  = $clog2(LN),
  localparam int unsigned PAW = $clog2(ADEP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [LN-1:0]   bitmap_i,
  input  logic [PAW-1:0]  offset_i,
  input  logic            wt_we_i,
  input  logic [IW-1:0]   wt_addr_i,
  input  logic [OW-1:0]   wt_data_i,
  input  logic            act_we_i,
  input  logic [PAW-1:0]  act_addr_i,
  input  logic [OW-1:0]  act_data_i,
  output logic [AW_R-1:0] result_o,
  output logic            done_o
);
  logic           run_q, done_q;
  logic           accept;
  logic           dec_valid;
  logic [IW-1:0]  dec_lane;
  logic [PAW-1:0] dec_fetch;
  logic [IW-1:0]  w_addr;
  logic [PAW-1:0] a_addr;
  logic [OW-1:0]  w_rd, a_rd;
  logic           mac_busy;

  assign accept = start_i & ~run_q;

  smac_index_dec #(.LANES(LN), .AW(PAW)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(accept), .mask(bitmap_i),
    .base(offset_i), .valid(dec_valid), .lane(dec_lane), .fetch(dec_fetch)
  );

  assign w_addr = run_q ? dec_lane  : wt_addr_i;
  assign a_addr = run_q ? dec_fetch : act_addr_i;

  smac_mem #(.DEPTH(LN), .WIDTH(OW)) u_wmem (
    .clk(clk), .we(wt_we_i & ~run_q), .addr(w_addr),
    .wdata(wt_data_i), .rdata(w_rd)
  );

  smac_mem #(.DEPTH(ADEP), .WIDTH(OW)) u_amem (
    .clk(clk), .we(act_we_i & ~run_q), .addr(a_addr),
    .wdata(act_data_i), .rdata(a_rd)
  );

  smac_mac #(.OPND_W(OW), .ACC_W(AW_R)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .issue(dec_valid & run_q),
    .w_rd(w_rd), .a_rd(a_rd), .acc(result_o), .busy(mac_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q && !dec_valid && !mac_busy) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !dec_valid && !mac_busy); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(result_o)); // R5
endmodule

// File: tb/sparse_mac_test.sv
`timescale 1ns/1ps
module sparse_mac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] bitmap_i = '0;
  logic [9:0]  offset_i = '0;
  logic        wt_we_i = 1'b0;
  logic [3:0]  wt_addr_i = '0;
  logic [15:0] wt_data_i = '0;
  logic        act_we_i = 1'b0;
  logic [9:0]  act_addr_i = '0;
  logic [15:0] act_data_i = '0;
  logic [31:0] result_o;
  logic        done_o;

  always #5 clk = ~clk;

  sparse_mac uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bitmap_i(bitmap_i),
    .offset_i(offset_i), .wt_we_i(wt_we_i), .wt_addr_i(wt_addr_i),
    .wt_data_i(wt_data_i), .act_we_i(act_we_i), .act_addr_i(act_addr_i),
    .act_data_i(act_data_i), .result_o(result_o), .done_o(done_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] wsh [16];
  logic [15:0] ash [1024];

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] bm, input logic [9:0] off);
    logic [31:0] acc;
    logic [9:0]  p;
    logic signed [31:0] pr;
    acc = '0;
    p = off;
    for (int i = 0; i < 16; i++) begin
      if (bm[i]) begin
        pr = $signed(wsh[i]) * $signed(ash[p]);
        acc = acc + pr;
        p = p + 10'd1;
      end
    end
    return acc;
  endfunction

  task automatic put_w(input int a, input logic [15:0] d);
    @(negedge clk);
    wt_we_i = 1'b1; wt_addr_i = 4'(a); wt_data_i = d;
    wsh[a] = d;
    @(negedge clk);
    wt_we_i = 1'b0;
  endtask

  task automatic put_a(input int a, input logic [15:0] d);
    @(negedge clk);
    act_we_i = 1'b1; act_addr_i = 10'(a); act_data_i = d;
    ash[a] = d;
    @(negedge clk);
    act_we_i = 1'b0;
  endtask

  // mode 0: plain, 1: stray start mid-job, 2: preload writes mid-job
  task automatic run_job(input logic [15:0] bm, input logic [9:0] off,
                         input int mode, input string tag);
    item_t it;
    int k;
    int n;
    int exp_lat;
    logic [31:0] held;
    it.exp = model(bm, off);
    it.tag = tag;
    sb_q.push_back(it);
    n = $countones(bm);
    exp_lat = (n == 0) ? 1 : n + 3;
    @(negedge clk);
    start_i = 1'b1; bitmap_i = bm; offset_i = off;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (1) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      start_i = 1'b0; act_we_i = 1'b0; wt_we_i = 1'b0;
      if (done_o || k > 60) break;
      if (k == 2 && mode == 1) begin
        start_i = 1'b1; bitmap_i = 16'hFFFF; offset_i = 10'd500;
      end
      if (k == 2 && mode == 2) begin
        act_we_i = 1'b1; act_addr_i = off; act_data_i = 16'h1234;
        wt_we_i = 1'b1; wt_addr_i = 4'd0; wt_data_i = 16'h4321;
      end
    end
    start_i = 1'b0; act_we_i = 1'b0; wt_we_i = 1'b0;
    if (n == 0)
      check(k == exp_lat, "R4 empty-mask done latency", 32'(k), 32'(exp_lat));
    else
      check(k == exp_lat, "R10 done latency", 32'(k), 32'(exp_lat));
    held = result_o;
    repeat (3) @(negedge clk);
    check(done_o && result_o == held, "R5 done and result held",
          result_o, held);
  endtask

  // monitor: scoreboard comparison on each rising done
  initial begin
    logic prev;
    item_t it;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done_o && !prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R5 done without job", result_o, 32'h0);
        end else begin
          it = sb_q.pop_front();
          check(result_o == it.exp, it.tag, result_o, it.exp);
        end
      end
      prev = done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(result_o == 32'h0, "R1 reset result", result_o, 32'h0);
    check(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_o == 32'h0 && !done_o, "R1 after release", result_o, 32'h0);

    for (int i = 0; i < 16; i++) put_w(i, 16'(i * 4099 - 30000));
    for (int i = 0; i < 1024; i++) put_a(i, 16'((i * 40503) ^ (i >> 3)));

    run_job(16'h0001, 10'd0,    0, "R2 single lane 0");
    run_job(16'hA5A5, 10'd100,  0, "R2 scattered mask");
    run_job(16'hFFFF, 10'd0,    0, "R9 dense mask");
    run_job(16'h0000, 10'd5,    0, "R4 empty mask result");
    run_job(16'h8000, 10'd1023, 0, "R8 top lane at last address");
    run_job(16'h0F0F, 10'd1020, 0, "R8 packed run wraps");
    run_job(16'h00F0, 10'd300,  1, "R6 stray start ignored");
    run_job(16'h0013, 10'd40,   2, "R7 writes during job");
    run_job(16'h0013, 10'd40,   0, "R7 store unchanged after job");
    run_job(16'h3C00, 10'd700,  0, "R2 back-to-back word 1");
    run_job(16'h0081, 10'd704,  0, "R2 back-to-back word 2");

    for (int i = 0; i < 16; i++) put_w(i, 16'h7FFF);
    for (int i = 0; i < 16; i++) put_a(i, 16'h7FFF);
    run_job(16'hFFFF, 10'd0, 0, "R3 wrap of 32-bit sum");
    put_w(2, 16'hFFFF);
    put_a(0, 16'h8000);
    put_w(5, 16'h8000);
    run_job(16'h0024, 10'd0, 0, "R3 signed operands");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R5 every job completed", 32'(sb_q.size()), 32'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule